// File: doc/BRIEF.md
# Partitioned SIMD Unsigned Comparator

This block compares two 16-bit operands as a set of independent unsigned lanes. The lane layout is chosen at run time by a 3-bit break vector, and the layout can change from one input to the next. Each break bit cuts the word between two adjacent nibbles. This gives any mix of 4-, 8-, 12- and 16-bit lanes. All six relations are produced together: equal, not-equal, less, less-or-equal, greater and greater-or-equal.

Each relation has a 4-bit output with one bit per nibble position. A lane's single verdict is copied onto every nibble bit that the lane covers, so a later stage can use the outputs directly as nibble-wide enables. The block is purely combinational. It has no clock and no state, and its outputs follow its inputs within the same evaluation.

Inside, each nibble pair is compared on its own. The nibble-level equal and greater results are then chained from the top nibble of each lane downward, and the chain is cut at every enabled break. The verdict formed at a lane's lowest nibble is copied back up across the lane.

Top module: `simd_part_cmp`

## Requirements
- R1: Bit k of `lane_brk` (k = 0..2), when set, places a lane boundary between nibble k (bits 4k+3..4k) and nibble k+1 of both operands. `3'b000` gives one 16-bit lane, `3'b010` gives two 8-bit lanes, and `3'b111` gives four 4-bit lanes.
- R2: Every bit of `rel_eq` that belongs to a lane is 1 exactly when that lane's bits of `op_a` and `op_b` are equal.
- R3: Every bit of `rel_gt` in a lane is 1 exactly when the lane value of `op_a` is greater than the lane value of `op_b`. The comparison is unsigned, so the lane's top bit counts as magnitude: 0x8000 is greater than 0x0000 in a 16-bit lane.
- R4: Every bit of `rel_lt` in a lane is 1 exactly when the unsigned lane value of `op_a` is less than that of `op_b`.
- R5: `rel_ne` is the bitwise complement of `rel_eq` in all four bits.
- R6: `rel_ge` equals `rel_gt | rel_eq`, and `rel_le` equals `rel_lt | rel_eq`, bit for bit.
- R7: All output bits of one lane carry the same value. With `lane_brk = 3'b010`, a true upper lane gives 4'b1100 and a true lower lane gives 4'b0011.
- R8: With four 4-bit lanes, output bit i reports nibble i: the most significant nibble drives bit 3 (4'b1000) and the least significant nibble drives bit 0 (4'b0001).
- R9: A lane's outputs depend only on that lane's operand bits. Changing the bits of another lane leaves them unchanged.
- R10: Uneven layouts work in the same way. For example, `3'b001` gives a 12-bit upper lane on bits 3..1 and a 4-bit lower lane on bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First operand, unsigned per lane |
| op_b | input | 16 | Second operand, unsigned per lane |
| lane_brk | input | 3 | Lane boundary enables between adjacent nibbles |
| rel_eq | output | 4 | Per-nibble copy of the lane's a == b verdict |
| rel_ne | output | 4 | Per-nibble copy of the lane's a != b verdict |
| rel_lt | output | 4 | Per-nibble copy of the lane's a < b verdict |
| rel_le | output | 4 | Per-nibble copy of the lane's a <= b verdict |
| rel_gt | output | 4 | Per-nibble copy of the lane's a > b verdict |
| rel_ge | output | 4 | Per-nibble copy of the lane's a >= b verdict |

## Verification
The bench targets operands that differ only in the lowest nibble, such as 0xABCD against 0xABCE. A chain that failed to carry equality down from the upper nibbles would give a wrong lane verdict there. The 0x8000 against 0x0000 case catches a design that treats the lane's top bit as a sign. 0xBEEF against 0xFEED gives opposite per-nibble verdicts, which exposes a chain that ignores a break and lets an upper nibble decide a lower lane. The bench sweeps all eight break layouts, including the uneven ones, to catch verdicts copied onto the wrong nibble bits or leaking across a boundary. It also checks that changing one lane's operand bits leaves another lane's outputs unchanged.

// File: rtl/simd_part_cmp_pkg.sv
package simd_part_cmp_pkg;
  // Per-slice raw comparison result
  typedef struct packed {
    logic eq;
    logic gt;
  } slice_rel_t;
endpackage

// File: rtl/simd_slice_cmp.sv
module simd_slice_cmp
  import simd_part_cmp_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] a_s,
  input  logic [SLICE_W-1:0] b_s,
  output slice_rel_t         rel
);
  always_comb begin
    rel.eq = (a_s == b_s);
    rel.gt = (a_s > b_s);
  end
endmodule

// File: rtl/simd_lane_chain.sv
// Chains slice results from each lane's top slice downward; c_*[i] covers
// the lane's slices from its top down to slice i.
module simd_lane_chain
  import simd_part_cmp_pkg::*;
#(
  parameter int N_SLICE = 4
) (
  input  slice_rel_t [N_SLICE-1:0] srel,
  input  logic       [N_SLICE-2:0] brk,
  output logic       [N_SLICE-1:0] c_eq,
  output logic       [N_SLICE-1:0] c_gt
);
  for (genvar i = N_SLICE - 1; i >= 0; i--) begin : g_chain
    if (i == N_SLICE - 1) begin : g_top
      assign c_eq[i] = srel[i].eq;
      assign c_gt[i] = srel[i].gt;
    end else begin : g_mid
      assign c_eq[i] = brk[i] ? srel[i].eq : (c_eq[i+1] & srel[i].eq);
      assign c_gt[i] = brk[i] ? srel[i].gt
                              : (c_gt[i+1] | (c_eq[i+1] & srel[i].gt));
    end
  end
endmodule

// File: rtl/simd_lane_spread.sv
// Copies the verdict held at each lane's lowest slice to all its slices.
module simd_lane_spread #(
  parameter int N_SLICE = 4
) (
  input  logic [N_SLICE-1:0] v_in,
  input  logic [N_SLICE-2:0] brk,
  output logic [N_SLICE-1:0] v_out
);
  for (genvar i = 0; i < N_SLICE; i++) begin : g_spread
    if (i == 0) begin : g_bot
      assign v_out[i] = v_in[i];
    end else begin : g_up
      assign v_out[i] = brk[i-1] ? v_in[i] : v_out[i-1];
    end
  end
endmodule

// File: rtl/simd_part_cmp.sv
module simd_part_cmp
  import simd_part_cmp_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int SLICE_W = 4,
  localparam int N_SLICE = WIDTH / SLICE_W
) (
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  input  logic [N_SLICE-2:0] lane_brk,
  output logic [N_SLICE-1:0] rel_eq,
  output logic [N_SLICE-1:0] rel_ne,
  output logic [N_SLICE-1:0] rel_lt,
  output logic [N_SLICE-1:0] rel_le,
  output logic [N_SLICE-1:0] rel_gt,
  output logic [N_SLICE-1:0] rel_ge
);
  slice_rel_t [N_SLICE-1:0] srel;
  logic [N_SLICE-1:0] c_eq, c_gt, l_eq, l_gt;

  for (genvar i = 0; i < N_SLICE; i++) begin : g_slice
    simd_slice_cmp #(.SLICE_W(SLICE_W)) u_slice (
      .a_s (op_a[i*SLICE_W +: SLICE_W]),
      .b_s (op_b[i*SLICE_W +: SLICE_W]),
      .rel (srel[i])
    );
  end

  simd_lane_chain #(.N_SLICE(N_SLICE)) u_chain (
    .srel (srel), .brk (lane_brk), .c_eq (c_eq), .c_gt (c_gt)
  );

  simd_lane_spread #(.N_SLICE(N_SLICE)) u_spread_eq (
    .v_in (c_eq), .brk (lane_brk), .v_out (l_eq)
  );
  simd_lane_spread #(.N_SLICE(N_SLICE)) u_spread_gt (
    .v_in (c_gt), .brk (lane_brk), .v_out (l_gt)
  );

  always_comb begin
    rel_eq = l_eq;
    rel_gt = l_gt;
    rel_ne = ~l_eq;
    rel_lt = ~(l_gt | l_eq);
    rel_le = ~l_gt;
    rel_ge = l_gt | l_eq;
  end
endmodule

// File: rtl/simd_part_cmp_chk.sv
module simd_part_cmp_chk #(
  parameter int WIDTH   = 16,
  parameter int SLICE_W = 4,
  localparam int N_SLICE = WIDTH / SLICE_W
) (
  input logic [WIDTH-1:0]   op_a,
  input logic [WIDTH-1:0]   op_b,
  input logic [N_SLICE-2:0] lane_brk,
  input logic [N_SLICE-1:0] rel_eq,
  input logic [N_SLICE-1:0] rel_ne,
  input logic [N_SLICE-1:0] rel_lt,
  input logic [N_SLICE-1:0] rel_le,
  input logic [N_SLICE-1:0] rel_gt,
  input logic [N_SLICE-1:0] rel_ge
);
  logic known;
  assign known = !$isunknown({op_a, op_b, lane_brk, rel_eq, rel_ne,
                              rel_lt, rel_le, rel_gt, rel_ge});

  always_comb begin
    if (known) begin
      // R5
      ne_compl_chk: assert (rel_ne == ~rel_eq);
      // R6
      ge_join_chk: assert (rel_ge == (rel_gt | rel_eq));
      // R6
      le_join_chk: assert (rel_le == (rel_lt | rel_eq));
      // R3
      lt_gt_excl_chk: assert ((rel_lt & rel_gt) == '0);
      // R4
      trichotomy_chk: assert ((rel_lt | rel_gt | rel_eq) == '1);
      // R2
      same_ops_chk: assert ((op_a != op_b) || (rel_eq == '1));
    end
  end

  for (genvar k = 0; k < N_SLICE - 1; k++) begin : g_uni
    always_comb begin
      if (known && !lane_brk[k]) begin
        // R7
        lane_uniform_chk: assert (rel_eq[k] == rel_eq[k+1] &&
                                  rel_gt[k] == rel_gt[k+1] &&
                                  rel_lt[k] == rel_lt[k+1]);
      end
    end
  end
endmodule

bind simd_part_cmp simd_part_cmp_chk #(.WIDTH(WIDTH), .SLICE_W(SLICE_W)) u_chk (
  .op_a(op_a), .op_b(op_b), .lane_brk(lane_brk),
  .rel_eq(rel_eq), .rel_ne(rel_ne), .rel_lt(rel_lt),
  .rel_le(rel_le), .rel_gt(rel_gt), .rel_ge(rel_ge)
);

// File: tb/simd_part_cmp_bench.sv
module simd_part_cmp_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic [15:0] op_a, op_b;
  logic [2:0]  lane_brk;
  logic [3:0]  rel_eq, rel_ne, rel_lt, rel_le, rel_gt, rel_ge;

  int n_chk = 0;
  int n_bad = 0;

  simd_part_cmp u_simd_part_cmp (
    .op_a(op_a), .op_b(op_b), .lane_brk(lane_brk),
    .rel_eq(rel_eq), .rel_ne(rel_ne), .rel_lt(rel_lt),
    .rel_le(rel_le), .rel_gt(rel_gt), .rel_ge(rel_ge)
  );

  // rel: 0 eq, 1 ne, 2 lt, 3 le, 4 gt, 5 ge
  function automatic logic [3:0] ref_rel(input logic [15:0] a,
      input logic [15:0] b, input logic [2:0] brk, input int rel);
    logic [3:0] r = '0;
    int lo = 0;
    for (int i = 0; i < 4; i++) begin
      if (i == 3 || brk[i]) begin
        logic [15:0] m = '0;
        logic v;
        for (int j = lo; j <= i; j++) m[j*4 +: 4] = 4'hF;
        case (rel)
          0: v = (a & m) == (b & m);
          1: v = (a & m) != (b & m);
          2: v = (a & m) <  (b & m);
          3: v = (a & m) <= (b & m);
          4: v = (a & m) >  (b & m);
          default: v = (a & m) >= (b & m);
        endcase
        for (int j = lo; j <= i; j++) r[j] = v;
        lo = i + 1;
      end
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [3:0] got,
                     input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h brk=%b got=%b exp=%b",
               tag, op_a, op_b, lane_brk, got, exp);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b,
                       input logic [2:0] brk);
    @(posedge clk);
    op_a = a; op_b = b; lane_brk = brk;
    @(negedge clk);
    chk("R2 eq", rel_eq, ref_rel(a, b, brk, 0));
    chk("R5 ne", rel_ne, ref_rel(a, b, brk, 1));
    chk("R4 lt", rel_lt, ref_rel(a, b, brk, 2));
    chk("R6 le", rel_le, ref_rel(a, b, brk, 3));
    chk("R3 gt", rel_gt, ref_rel(a, b, brk, 4));
    chk("R6 ge", rel_ge, ref_rel(a, b, brk, 5));
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] pa [10] = '{16'h0000, 16'h1234, 16'hABCD, 16'hFFFF,
        16'h0000, 16'hFFFF, 16'h0000, 16'hABCD, 16'h8000, 16'hBEEF};
    logic [15:0] pb [10] = '{16'h0000, 16'h1234, 16'hABCD, 16'h0000,
        16'h0000, 16'hFFFF, 16'hFFFF, 16'hABCE, 16'h0000, 16'hFEED};
    logic [3:0] keep;
    int unsigned seed;
    op_a = '0; op_b = '0; lane_brk = '0;
    seed = $urandom(32'd2024);
    // idle state: zero operands compare equal everywhere (R2)
    @(negedge clk);
    chk("R2 idle eq", rel_eq, 4'b1111);
    chk("R5 idle ne", rel_ne, 4'b0000);

    // directed pairs under every layout (R1, R10)
    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 10; p++) apply(pa[p], pb[p], 3'(m));

    // R3: sign position is magnitude in a 16-bit lane
    apply(16'h8000, 16'h0000, 3'b000);
    chk("R3 msb unsigned", rel_gt, 4'b1111);
    // R7: two 8-bit lanes, upper true, lower false
    apply(16'hBE00, 16'hBE01, 3'b010);
    chk("R7 upper lane eq", rel_eq, 4'b1100);
    chk("R7 lower lane lt", rel_lt, 4'b0011);
    // R8: four lanes, only top nibble greater, only bottom nibble greater
    apply(16'h9000, 16'h1000, 3'b111);
    chk("R8 msn bit3", rel_gt, 4'b1000);
    apply(16'h0009, 16'h0001, 3'b111);
    chk("R8 lsn bit0", rel_gt, 4'b0001);
    // R10: 12-bit upper lane over a 4-bit lower lane
    apply(16'h1235, 16'h1244, 3'b001);
    chk("R10 uneven lt", rel_lt, 4'b1110);
    chk("R10 uneven gt", rel_gt, 4'b0001);
    // R9: changing the upper lane leaves the lower lane's verdict alone
    apply(16'h12AB, 16'h34AB, 3'b010);
    keep = rel_eq;
    apply(16'hF0AB, 16'h34AB, 3'b010);
    chk("R9 lower lane kept", rel_eq & 4'b0011, keep & 4'b0011);
    chk("R1 brk split", rel_eq, 4'b0011);

    // constrained random: mostly near-equal operands
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a = 16'($urandom);
      logic [15:0] b = a ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
      if (n % 5 == 0) b = 16'($urandom);
      apply(a, b, 3'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule